// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Control

This block decides, for the instruction now in the execute stage of a five-stage RV32I integer pipeline, where each register operand should come from. An operand can come from the register-file read captured at decode, from the result held by the instruction one stage ahead (memory stage), or from the data being written back by the instruction two stages ahead (writeback stage). The block is purely combinational. It compares the execute-stage source register numbers against the destination registers of the two older instructions and drives the select lines of the operand muxes that sit in front of the ALU.

Which sources are compared depends on the opcode class of the execute-stage instruction, so that a field holding immediate bits never causes a false match. When both older instructions write the wanted register, the memory-stage match wins, because its data is newer. Stores get a separate select for their store-data path: the ALU's second input takes the immediate, while the forwarded rs2 value is captured as the data to be stored.

The block also chooses which value the memory stage offers for forwarding. It reuses that instruction's writeback-source select for this, so that results of lui, jal and jalr can be forwarded one cycle after they execute, and not only ALU results.

Top module: `fwd_unit`

## Requirements
- R1: Operand A select is 2'b10 (memory stage) when mem_wen is 1, mem_rd is nonzero and equals ex_rs1, and ex_opcode is one of 0110011, 0010011, 0000011, 1100111, 0100011 or 1100011.
- R2: Operand B select is 2'b10 (memory stage) when mem_wen is 1, mem_rd is nonzero and equals ex_rs2, and ex_opcode is one of 0110011, 0100011 or 1100011.
- R3: Operand A select is 2'b01 (writeback stage) when R1 does not apply, wb_wen is 1, wb_rd is nonzero and equals ex_rs1, and the opcode is in the R1 list.
- R4: Operand B select is 2'b01 (writeback stage) when R2 does not apply, wb_wen is 1, wb_rd is nonzero and equals ex_rs2, and the opcode is in the R2 list.
- R5: When the memory and writeback stages both write the same register that an operand reads, that operand's select is 2'b10.
- R6: A destination of register 0, a disabled write or an unmatched register number never forwards: the select stays 2'b00 (register file).
- R7: Opcodes outside the classes of R1 and R2 (for example 0110111 and 1101111) give 2'b00 on the operand A, operand B and store-data selects.
- R8: No operand select ever takes the value 2'b11.
- R9: The store-data select equals the operand B select when ex_opcode is 0100011 and is 2'b00 for every other opcode.
- R10: The memory-stage value select is 2'b01 (upper immediate) when mem_wbsel is 2'b11, 2'b10 (link address) when mem_wbsel is 2'b10, and 2'b00 (ALU result) when mem_wbsel is 2'b00 or 2'b01 (load data).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_opcode | input | 7 | Opcode of the execute-stage instruction |
| ex_rs1 | input | 5 | First source register number in execute |
| ex_rs2 | input | 5 | Second source register number in execute |
| mem_rd | input | 5 | Destination register of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_wbsel | input | 2 | Writeback source of the memory-stage instruction: 00 ALU, 01 load, 10 link, 11 upper immediate |
| wb_rd | input | 5 | Destination register of the writeback-stage instruction |
| wb_wen | input | 1 | Writeback-stage instruction writes a register |
| sel_a | output | 2 | Operand A mux select: 00 register file, 01 writeback, 10 memory stage |
| sel_b | output | 2 | Operand B (rs2 value) mux select, same encoding |
| sel_st | output | 2 | Store-data mux select, same encoding |
| mem_val_sel | output | 2 | Value the memory stage forwards: 00 ALU result, 01 upper immediate, 10 link address |

## Verification
The assertions check on every input change that no select is 2'b11, that any forwarding select points at a stage that really writes the matching nonzero register, that the store-data select is idle outside stores, and that non-source opcodes never forward. Only the bench's scenarios can show the full priority behaviour and that a forward is not missed. The bench sweeps all opcode classes against matching, non-matching and zero register numbers in both older stages, with every write-enable and writeback-source combination, and compares the results with an independent priority model.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int REG_AW = 5;
  localparam int OP_W   = 7;
  localparam int SEL_W  = 2;

  localparam logic [OP_W-1:0] OPC_ALU_R  = 7'b0110011;
  localparam logic [OP_W-1:0] OPC_ALU_I  = 7'b0010011;
  localparam logic [OP_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OP_W-1:0] OPC_JALR   = 7'b1100111;
  localparam logic [OP_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OP_W-1:0] OPC_BRANCH = 7'b1100011;

  localparam logic [SEL_W-1:0] SRC_RF  = 2'b00;
  localparam logic [SEL_W-1:0] SRC_WB  = 2'b01;
  localparam logic [SEL_W-1:0] SRC_MEM = 2'b10;

  localparam logic [1:0] WBS_ALU  = 2'b00;
  localparam logic [1:0] WBS_LOAD = 2'b01;
  localparam logic [1:0] WBS_LINK = 2'b10;
  localparam logic [1:0] WBS_UIMM = 2'b11;

  localparam logic [SEL_W-1:0] MV_ALU  = 2'b00;
  localparam logic [SEL_W-1:0] MV_UIMM = 2'b01;
  localparam logic [SEL_W-1:0] MV_LINK = 2'b10;
endpackage

// File: rtl/fwd_opclass.sv
module fwd_opclass
  import fwd_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output logic            reads_rs1,
  output logic            reads_rs2,
  output logic            is_store
);
  always_comb begin
    reads_rs1 = 1'b0;
    reads_rs2 = 1'b0;
    is_store  = 1'b0;
    unique case (opcode)
      OPC_ALU_R, OPC_BRANCH: begin
        reads_rs1 = 1'b1;
        reads_rs2 = 1'b1;
      end
      OPC_STORE: begin
        reads_rs1 = 1'b1;
        reads_rs2 = 1'b1;
        is_store  = 1'b1;
      end
      OPC_ALU_I, OPC_LOAD, OPC_JALR: reads_rs1 = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/fwd_src_pick.sv
module fwd_src_pick
  import fwd_pkg::*;
#(
  parameter int AW = REG_AW
) (
  input  logic [AW-1:0]    rs,
  input  logic             rs_used,
  input  logic [AW-1:0]    mem_rd,
  input  logic             mem_wen,
  input  logic [AW-1:0]    wb_rd,
  input  logic             wb_wen,
  output logic [SEL_W-1:0] sel
);
  logic mem_hit, wb_hit;

  always_comb begin
    mem_hit = rs_used && mem_wen && (mem_rd != '0) && (mem_rd == rs);
    wb_hit  = rs_used && wb_wen  && (wb_rd  != '0) && (wb_rd  == rs);
    if (mem_hit)     sel = SRC_MEM;
    else if (wb_hit) sel = SRC_WB;
    else             sel = SRC_RF;
  end
endmodule

// File: rtl/fwd_memval.sv
module fwd_memval
  import fwd_pkg::*;
(
  input  logic [1:0]       wbsel,
  output logic [SEL_W-1:0] val_sel
);
  always_comb begin
    unique case (wbsel)
      WBS_UIMM: val_sel = MV_UIMM;
      WBS_LINK: val_sel = MV_LINK;
      WBS_LOAD: val_sel = MV_ALU;
      default:  val_sel = MV_ALU;
    endcase
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
(
  input  logic [6:0] ex_opcode,
  input  logic [4:0] ex_rs1,
  input  logic [4:0] ex_rs2,
  input  logic [4:0] mem_rd,
  input  logic       mem_wen,
  input  logic [1:0] mem_wbsel,
  input  logic [4:0] wb_rd,
  input  logic       wb_wen,
  output logic [1:0] sel_a,
  output logic [1:0] sel_b,
  output logic [1:0] sel_st,
  output logic [1:0] mem_val_sel
);
  localparam int NOPS = 2;

  logic              use_rs1, use_rs2, st_op;
  logic [REG_AW-1:0] rs_v   [NOPS];
  logic              used_v [NOPS];
  logic [SEL_W-1:0]  sel_v  [NOPS];

  fwd_opclass u_cls (
    .opcode    (ex_opcode),
    .reads_rs1 (use_rs1),
    .reads_rs2 (use_rs2),
    .is_store  (st_op)
  );

  assign rs_v[0]   = ex_rs1;
  assign rs_v[1]   = ex_rs2;
  assign used_v[0] = use_rs1;
  assign used_v[1] = use_rs2;

  for (genvar g = 0; g < NOPS; g++) begin : g_opnd
    fwd_src_pick #(.AW(REG_AW)) u_pick (
      .rs      (rs_v[g]),
      .rs_used (used_v[g]),
      .mem_rd  (mem_rd),
      .mem_wen (mem_wen),
      .wb_rd   (wb_rd),
      .wb_wen  (wb_wen),
      .sel     (sel_v[g])
    );
  end

  assign sel_a  = sel_v[0];
  assign sel_b  = sel_v[1];
  assign sel_st = st_op ? sel_v[1] : SRC_RF;

  fwd_memval u_mv (
    .wbsel   (mem_wbsel),
    .val_sel (mem_val_sel)
  );

  always_comb begin
    // R8
    sel_range_chk: assert (sel_a != 2'b11 && sel_b != 2'b11 && sel_st != 2'b11);
    // R1
    a_mem_src_chk: assert (sel_a != SRC_MEM || (mem_wen && mem_rd == ex_rs1 && mem_rd != '0));
    // R3
    a_wb_src_chk: assert (sel_a != SRC_WB || (wb_wen && wb_rd == ex_rs1 && wb_rd != '0));
    // R2
    b_mem_src_chk: assert (sel_b != SRC_MEM || (mem_wen && mem_rd == ex_rs2 && mem_rd != '0));
    // R4
    b_wb_src_chk: assert (sel_b != SRC_WB || (wb_wen && wb_rd == ex_rs2 && wb_rd != '0));
    // R5
    mem_first_chk: assert (!(mem_wen && wb_wen && mem_rd == wb_rd) || sel_a != SRC_WB);
    // R9
    st_idle_chk: assert (ex_opcode == OPC_STORE || sel_st == SRC_RF);
    // R7
    nosrc_chk: assert (ex_opcode == OPC_ALU_R || ex_opcode == OPC_ALU_I ||
                       ex_opcode == OPC_LOAD || ex_opcode == OPC_JALR ||
                       ex_opcode == OPC_STORE || ex_opcode == OPC_BRANCH ||
                       (sel_a == SRC_RF && sel_b == SRC_RF));
    // R10
    memval_range_chk: assert (mem_val_sel != 2'b11);
  end
endmodule

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb;
  logic clk;
  logic rst_n;
  logic [6:0] ex_opcode;
  logic [4:0] ex_rs1, ex_rs2, mem_rd, wb_rd;
  logic       mem_wen, wb_wen;
  logic [1:0] mem_wbsel;
  logic [1:0] sel_a, sel_b, sel_st, mem_val_sel;

  typedef struct {
    logic [1:0] a, b, st, mv;
    int ta, tb;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit drv_done = 0;

  fwd_unit u_dut (
    .ex_opcode (ex_opcode), .ex_rs1 (ex_rs1), .ex_rs2 (ex_rs2),
    .mem_rd (mem_rd), .mem_wen (mem_wen), .mem_wbsel (mem_wbsel),
    .wb_rd (wb_rd), .wb_wen (wb_wen),
    .sel_a (sel_a), .sel_b (sel_b), .sel_st (sel_st), .mem_val_sel (mem_val_sel)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic string tag_name(int t);
    case (t)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [6:0] op_of(int i);
    case (i)
      0: return 7'b0110011;
      1: return 7'b0010011;
      2: return 7'b0000011;
      3: return 7'b1100111;
      4: return 7'b0100011;
      5: return 7'b1100011;
      6: return 7'b0110111;
      7: return 7'b1101111;
      default: return 7'b0010111;
    endcase
  endfunction

  function automatic logic [4:0] reg_of(int i);
    case (i)
      0: return 5'd0;
      1: return 5'd3;
      default: return 5'd5;
    endcase
  endfunction

  // Reference priority model; tag reports which requirement decided the result.
  function automatic void model(input logic [4:0] rs, input bit used, input bit known,
                                input logic [4:0] mrd, input logic mw,
                                input logic [4:0] wrd, input logic ww,
                                input int t_mem, input int t_wb,
                                output logic [1:0] sel, output int tag);
    bit m, w;
    m = used && mw && (mrd == rs) && (rs != 5'd0);
    w = used && ww && (wrd == rs) && (rs != 5'd0);
    if (m && w)      begin sel = 2'b10; tag = 5; end
    else if (m)      begin sel = 2'b10; tag = t_mem; end
    else if (w)      begin sel = 2'b01; tag = t_wb; end
    else if (!known) begin sel = 2'b00; tag = 7; end
    else             begin sel = 2'b00; tag = 6; end
  endfunction

  task automatic drive(logic [6:0] op, logic [4:0] r1, logic [4:0] r2,
                       logic [4:0] mrd, logic mw, logic [1:0] ws,
                       logic [4:0] wrd, logic ww);
    exp_t e;
    bit a_use, b_use, known, st;
    @(posedge clk);
    ex_opcode = op; ex_rs1 = r1; ex_rs2 = r2;
    mem_rd = mrd; mem_wen = mw; mem_wbsel = ws; wb_rd = wrd; wb_wen = ww;
    st    = (op == 7'b0100011);
    b_use = (op == 7'b0110011) || st || (op == 7'b1100011);
    a_use = b_use || (op == 7'b0010011) || (op == 7'b0000011) || (op == 7'b1100111);
    known = a_use;
    model(r1, a_use, known, mrd, mw, wrd, ww, 1, 3, e.a, e.ta);
    model(r2, b_use, known, mrd, mw, wrd, ww, 2, 4, e.b, e.tb);
    e.st = st ? e.b : 2'b00;
    e.mv = (ws == 2'b11) ? 2'b01 : (ws == 2'b10) ? 2'b10 : 2'b00;
    q.push_back(e);
  endtask

  task automatic cmp(string what, string tag, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b (op %b rs1 %0d rs2 %0d mrd %0d mw %b ws %b wrd %0d ww %b)",
               tag, what, act, exp, ex_opcode, ex_rs1, ex_rs2, mem_rd, mem_wen, mem_wbsel, wb_rd, wb_wen);
    end
  endtask

  // monitor: compares one expected item per cycle, away from the driving edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp("sel_a", tag_name(e.ta), sel_a, e.a);
        cmp("sel_b", tag_name(e.tb), sel_b, e.b);
        cmp("sel_st", "R9", sel_st, e.st);
        cmp("mem_val_sel", "R10", mem_val_sel, e.mv);
        n_chk++;
        if (sel_a == 2'b11 || sel_b == 2'b11) begin
          n_fail++;
          $display("FAIL R8: actual a=%b b=%b expected no 11", sel_a, sel_b);
        end
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    ex_opcode = '0; ex_rs1 = '0; ex_rs2 = '0; mem_rd = '0; mem_wen = 1'b0;
    mem_wbsel = '0; wb_rd = '0; wb_wen = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle state: nothing writes, all selects at register file (R6)
    drive(7'b0110011, 5'd0, 5'd0, 5'd0, 1'b0, 2'b00, 5'd0, 1'b0);
    // directed: lui in memory stage feeding an addi (R1, R10)
    drive(7'b0010011, 5'd5, 5'd9, 5'd5, 1'b1, 2'b11, 5'd0, 1'b0);
    // directed: store data forwarded from writeback, address from memory (R9)
    drive(7'b0100011, 5'd3, 5'd5, 5'd3, 1'b1, 2'b00, 5'd5, 1'b1);
    // exhaustive sweep over classes and register relations
    for (int oi = 0; oi < 9; oi++)
      for (int a = 0; a < 3; a++)
        for (int b = 0; b < 3; b++)
          for (int m = 0; m < 3; m++)
            for (int w = 0; w < 3; w++)
              for (int en = 0; en < 4; en++)
                for (int ws = 0; ws < 4; ws++)
                  drive(op_of(oi), reg_of(a), reg_of(b), reg_of(m), en[0],
                        ws[1:0], reg_of(w), en[1]);
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    drv_done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!drv_done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule